// File: doc/BRIEF.md
# SPI Master Transfer Framing Controller

This block paces an SPI master's byte shifter. It holds a 14-bit byte count and a repeat flag, and from them and a few mode inputs it decides when the next byte may start. It also decides when chip select should drop between frames, and when a whole transfer is finished. A single count serves two uses. It is either the total for a one-shot transfer or the length of every frame in a repeating stream. A count of zero means the link streams for as long as the FIFO in use can keep up.

The shifter takes a one-cycle `start_byte` pulse, which it cannot refuse, and answers with a one-cycle `byte_done` pulse when the byte has been shifted. Back-pressure comes only from the FIFO flags. While the selected FIFO is not ready, no byte starts, and an open frame simply waits with chip select held. The FIFO in use is the transmit FIFO (`tx_rdy`, data available) when `dir_rx` is 0, and the receive FIFO (`rx_rdy`, space available) when `dir_rx` is 1. In 16-bit DMA mode, a frame with an odd byte count ends with a one-cycle marker. On transmit the marker tells the half-word packer to pad the final half-word. On receive it tells the packer to discard the extra byte.

Top module: `spi_frame_ctl`

## Requirements
- R1: The count and repeat flag load on `cnt_wr` only while `ctl_en` is 1. Dropping `ctl_en` forces the stored count to zero and closes any open frame. A `cnt_wr` after a finished transfer starts a new one.
- R2: With `multi_en`=1, `cont_wdata`=0 and a count N>0, exactly one frame carrying N `start_byte` pulses is produced. After it, `xfer_done` goes to 1 and stays there with no further starts until the next `cnt_wr` or the next disable.
- R3: With `multi_en`=1, the repeat flag set and N>0, frames of exactly N bytes repeat, and `xfer_done` stays 0.
- R4: With `multi_en`=1 and a count of 0, a single frame stays open and bytes start whenever the FIFO is ready. The repeat flag has no effect, and `xfer_done` stays 0.
- R5: With `multi_en`=0, every frame carries exactly one byte whatever the count and the repeat flag are. Frames keep repeating, and `xfer_done` stays 0.
- R6: Between two consecutive frames, `frame_active` is 0 for at least one clock.
- R7: `start_byte` pulses only while `frame_active` is 1 and the selected FIFO is ready, and never while a byte is still waiting for its `byte_done`. A FIFO stall inside a frame keeps `frame_active` at 1.
- R8: A frame opens (`frame_active` rises) only after the selected FIFO was ready.
- R9: When `dma16`=1, `multi_en`=1 and the count is odd, the cycle just after `frame_active` falls carries a one-cycle pulse. The pulse is on `half_pad` when `dir_rx`=0 and on `half_drop` when `dir_rx`=1. An even count gives neither pulse, and neither pulse occurs at any other time.
- R10: During reset, `start_byte`, `frame_active`, `xfer_done`, `half_pad` and `half_drop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable; 0 clears the count and closes any frame |
| multi_en | input | 1 | 1 = frames of the programmed length; 0 = one-byte frames |
| dma16 | input | 1 | 16-bit DMA mode (enables the pad/drop markers) |
| dir_rx | input | 1 | 0 = transmit transfer (use tx_rdy), 1 = receive transfer (use rx_rdy) |
| cnt_wr | input | 1 | Write strobe for the count and the repeat flag |
| cnt_wdata | input | 14 | Byte count to store |
| cont_wdata | input | 1 | Repeat flag to store |
| tx_rdy | input | 1 | Transmit FIFO holds data |
| rx_rdy | input | 1 | Receive FIFO has space |
| byte_done | input | 1 | Shifter finished the current byte |
| start_byte | output | 1 | One-cycle request to shift a byte |
| frame_active | output | 1 | Frame open; drives chip select |
| xfer_done | output | 1 | One-shot transfer complete |
| half_pad | output | 1 | Pad the final half-word (transmit, odd count) |
| half_drop | output | 1 | Discard the extra byte of the final half-word (receive, odd count) |

## Verification
The bench aims at the frame boundary. If the design missed the last byte, or kept going past it, every frame length in the scoreboard would come out one byte off. If it merged repeating frames without a chip-select gap, one long frame would appear where several were expected. A design whose count survives a disable would show a one-shot transfer after re-enable instead of an open stream. A design that starts bytes from the wrong FIFO flag would either stall a receive transfer or run on through a transmit stall. The odd/even and transmit/receive cases of 16-bit DMA, and a one-byte count, show whether the pad and drop markers land on the right side and in the right cycle.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP,
    ST_DONE
  } fr_state_e;

  typedef struct packed {
    logic stream;
    logic repeat_f;
    logic odd16;
    logic rx;
  } frame_mode_t;

endpackage

// File: rtl/spi_frame_cfg.sv
module spi_frame_cfg #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cont_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cont_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl_en) begin
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt_q  <= cnt_wdata;
      cont_q <= cont_wdata;
    end
  end

endmodule

// File: rtl/spi_frame_cnt.sv
module spi_frame_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_zero,
  output logic             rem_last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rem <= '0;
    else if (load)
      rem <= load_val;
    else if (dec)
      rem <= rem - ONE;
  end

  assign rem_zero = (rem == '0);
  assign rem_last = (rem == ONE);

  // A decrement must never wrap the remaining-bytes counter
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !rem_zero);

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_frame_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             multi_en,
  input  logic             dma16,
  input  logic             dir_rx,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cont_q,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  input  logic             byte_done,
  input  logic             rem_zero,
  input  logic             rem_last,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             cnt_dec,
  output logic             start_byte,
  output logic             frame_active,
  output logic             xfer_done,
  output logic             half_pad,
  output logic             half_drop
);

  fr_state_e   st;
  frame_mode_t mode;
  frame_mode_t mode_nx;
  logic        busy;
  logic        pad_q;
  logic        drop_q;
  logic        fifo_ok;
  logic        open_f;
  logic        frame_end;

  assign fifo_ok      = dir_rx ? rx_rdy : tx_rdy;
  assign open_f       = (st == ST_IDLE) && ctl_en && fifo_ok && !cnt_wr;
  assign start_byte   = (st == ST_RUN) && !busy && fifo_ok && (mode.stream || !rem_zero);
  assign cnt_dec      = (st == ST_RUN) && busy && byte_done && !mode.stream;
  assign frame_end    = cnt_dec && rem_last;
  assign cnt_load     = open_f;
  assign cnt_load_val = multi_en ? cnt_q : CNT_W'(1);

  always_comb begin
    mode_nx.stream   = multi_en && (cnt_q == '0);
    mode_nx.repeat_f = !multi_en || cont_q;
    mode_nx.odd16    = multi_en && dma16 && cnt_q[0];
    mode_nx.rx       = dir_rx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl_en) begin
      st     <= ST_IDLE;
      mode   <= '0;
      busy   <= 1'b0;
      pad_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      pad_q  <= frame_end && mode.odd16 && !mode.rx;
      drop_q <= frame_end && mode.odd16 && mode.rx;
      if (start_byte)
        busy <= 1'b1;
      else if (byte_done)
        busy <= 1'b0;
      case (st)
        ST_IDLE: if (open_f) begin
          st   <= ST_RUN;
          mode <= mode_nx;
        end
        ST_RUN:  if (frame_end) st <= ST_GAP;
        ST_GAP:  st <= mode.repeat_f ? ST_IDLE : ST_DONE;
        ST_DONE: if (cnt_wr) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign frame_active = (st == ST_RUN);
  assign xfer_done    = (st == ST_DONE);
  assign half_pad     = pad_q;
  assign half_drop    = drop_q;

  assert_start_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_byte |-> frame_active);

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_byte |=> !start_byte);

  assert_open_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(dir_rx ? rx_rdy : tx_rdy));

  assert_done_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !frame_active);

  assert_marker_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_pad && half_drop));

  assert_marker_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (half_pad || half_drop) |-> (!frame_active && $past(frame_active)));

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             multi_en,
  input  logic             dma16,
  input  logic             dir_rx,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cont_wdata,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  input  logic             byte_done,
  output logic             start_byte,
  output logic             frame_active,
  output logic             xfer_done,
  output logic             half_pad,
  output logic             half_drop
);

  logic [CNT_W-1:0] cnt_q;
  logic             cont_q;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cnt_dec;
  logic             rem_zero;
  logic             rem_last;

  spi_frame_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cont_wdata (cont_wdata),
    .cnt_q      (cnt_q),
    .cont_q     (cont_q)
  );

  spi_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .rem_zero (rem_zero),
    .rem_last (rem_last)
  );

  spi_frame_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en       (ctl_en),
    .multi_en     (multi_en),
    .dma16        (dma16),
    .dir_rx       (dir_rx),
    .cnt_wr       (cnt_wr),
    .cnt_q        (cnt_q),
    .cont_q       (cont_q),
    .tx_rdy       (tx_rdy),
    .rx_rdy       (rx_rdy),
    .byte_done    (byte_done),
    .rem_zero     (rem_zero),
    .rem_last     (rem_last),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_dec      (cnt_dec),
    .start_byte   (start_byte),
    .frame_active (frame_active),
    .xfer_done    (xfer_done),
    .half_pad     (half_pad),
    .half_drop    (half_drop)
  );

endmodule

// File: tb/test_spi_frame_ctl.sv
`timescale 1ns/1ps
module test_spi_frame_ctl;

  localparam int CNT_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_en = 1'b0, multi_en = 1'b0, dma16 = 1'b0, dir_rx = 1'b0;
  logic cnt_wr = 1'b0, cont_wdata = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic tx_rdy = 1'b0, rx_rdy = 1'b0;
  logic byte_done = 1'b0;
  logic start_byte, frame_active, xfer_done, half_pad, half_drop;

  always #4 clk = ~clk;  // 125 MHz

  spi_frame_ctl #(.CNT_W(CNT_W)) i_spi_frame_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .multi_en(multi_en),
    .dma16(dma16), .dir_rx(dir_rx), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cont_wdata(cont_wdata), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
    .byte_done(byte_done), .start_byte(start_byte),
    .frame_active(frame_active), .xfer_done(xfer_done),
    .half_pad(half_pad), .half_drop(half_drop)
  );

  typedef struct {
    int    len;
    bit    pad;
    bit    drop;
    string tag;
  } frame_exp_t;

  frame_exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  int total_starts = 0, frame_falls = 0;
  bit mon_ignore = 1'b0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Shifter model: byte_done three cycles after the start is seen
  int sh_cnt = 0;
  always @(posedge clk) begin
    byte_done <= 1'b0;
    if (!rst_n) sh_cnt <= 0;
    else if (start_byte) sh_cnt <= 3;
    else if (sh_cnt != 0) begin
      sh_cnt <= sh_cnt - 1;
      if (sh_cnt == 1) byte_done <= 1'b1;
    end
  end

  // Monitor: counts bytes per frame and pops the scoreboard at each frame end
  bit prev_fa = 1'b0;
  bit outstanding = 1'b0;
  int nbytes = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_byte) begin
        total_starts++;
        if (frame_active) nbytes++;
        if (!frame_active) chk(0, "R7", "start outside frame", 1, 0);
        if (!(dir_rx ? rx_rdy : tx_rdy)) chk(0, "R7", "start with FIFO not ready", 1, 0);
        if (outstanding) chk(0, "R7", "start with byte outstanding", 1, 0);
      end
      if (byte_done) outstanding = 1'b0;
      if (start_byte) outstanding = 1'b1;
      if ((half_pad || half_drop) && !(prev_fa && !frame_active))
        chk(0, "R9", "marker outside frame end", 1, 0);
      if (prev_fa && !frame_active) begin
        frame_falls++;
        if (!mon_ignore) begin
          if (exp_q.size() == 0) chk(0, "R2", "unexpected frame end", nbytes, 0);
          else begin
            frame_exp_t e;
            e = exp_q.pop_front();
            chk(nbytes == e.len, e.tag, "frame length", nbytes, e.len);
            chk(half_pad == e.pad, e.tag, "half_pad at frame end", int'(half_pad), int'(e.pad));
            chk(half_drop == e.drop, e.tag, "half_drop at frame end", int'(half_drop), int'(e.drop));
          end
        end
        nbytes = 0;
      end
      prev_fa = frame_active;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push_frames(int n, int len, bit pad, bit drop, string tag);
    for (int i = 0; i < n; i++) begin
      frame_exp_t e;
      e.len = len; e.pad = pad; e.drop = drop; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) tick(1);
    tick(1);
  endtask

  task automatic setup(int count, bit cont, bit multi, bit dm, bit rx);
    mon_ignore = 1'b1;
    tx_rdy = 1'b0; rx_rdy = 1'b0;
    ctl_en = 1'b0;
    tick(3);
    ctl_en = 1'b1; multi_en = multi; dma16 = dm; dir_rx = rx;
    cnt_wr = 1'b1; cnt_wdata = CNT_W'(count); cont_wdata = cont;
    tick(1);
    cnt_wr = 1'b0;
    tick(1);
    exp_q.delete();
    mon_ignore = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int s0, f0;
    tick(3);
    @(negedge clk);
    chk(frame_active == 0 && start_byte == 0 && xfer_done == 0 &&
        half_pad == 0 && half_drop == 0, "R10", "outputs in reset",
        int'({start_byte, frame_active, xfer_done, half_pad, half_drop}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(2);

    // R2: one-shot frame of 5, then done and silent
    setup(5, 0, 1, 0, 0);
    push_frames(1, 5, 0, 0, "R2");
    tx_rdy = 1'b1;
    wait_empty();
    s0 = total_starts;
    tick(60);
    chk(xfer_done == 1, "R2", "xfer_done after one-shot", int'(xfer_done), 1);
    chk(total_starts == s0, "R2", "starts after done", total_starts - s0, 0);
    // R1: rewrite re-arms a finished transfer
    cnt_wr = 1'b1; cnt_wdata = CNT_W'(2); cont_wdata = 1'b0;
    push_frames(1, 2, 0, 0, "R1");
    tick(1);
    cnt_wr = 1'b0;
    wait_empty();
    tick(3);
    chk(xfer_done == 1, "R1", "done after re-armed transfer", int'(xfer_done), 1);

    // R3 and R6: repeating frames of 3, separated by a gap
    setup(3, 1, 1, 0, 0);
    push_frames(4, 3, 0, 0, "R3 R6");
    tx_rdy = 1'b1;
    wait_empty();
    chk(xfer_done == 0, "R3", "done while repeating", int'(xfer_done), 0);

    // R4: zero count streams in one open frame
    setup(0, 0, 1, 0, 0);
    s0 = total_starts; f0 = frame_falls;
    tx_rdy = 1'b1;
    tick(80);
    chk(frame_active == 1, "R4", "frame open while streaming", int'(frame_active), 1);
    chk(total_starts - s0 >= 10, "R4", "bytes streamed", total_starts - s0, 10);
    chk(frame_falls == f0, "R4", "frame ends while streaming", frame_falls - f0, 0);
    chk(xfer_done == 0, "R4", "done while streaming", int'(xfer_done), 0);

    // R5: multi-byte framing off gives one-byte frames
    setup(4, 0, 0, 0, 0);
    push_frames(5, 1, 0, 0, "R5 R6");
    tx_rdy = 1'b1;
    wait_empty();
    chk(xfer_done == 0, "R5", "done with one-byte frames", int'(xfer_done), 0);

    // R9: 16-bit DMA markers
    setup(3, 0, 1, 1, 0);
    push_frames(1, 3, 1, 0, "R9");
    tx_rdy = 1'b1;
    wait_empty();
    setup(5, 0, 1, 1, 1);
    push_frames(1, 5, 0, 1, "R9");
    rx_rdy = 1'b1;  // tx_rdy stays low: receive must use rx_rdy (R7)
    wait_empty();
    chk(xfer_done == 1, "R7", "receive ran on rx_rdy alone", int'(xfer_done), 1);
    setup(4, 0, 1, 1, 0);
    push_frames(1, 4, 0, 0, "R9");
    tx_rdy = 1'b1;
    wait_empty();
    setup(1, 0, 1, 1, 0);
    push_frames(1, 1, 1, 0, "R9");
    tx_rdy = 1'b1;
    wait_empty();

    // R7: FIFO stall inside a frame
    setup(6, 0, 1, 0, 0);
    push_frames(1, 6, 0, 0, "R7");
    s0 = total_starts;
    tx_rdy = 1'b1;
    while (total_starts - s0 < 2) tick(1);
    tx_rdy = 1'b0;
    f0 = total_starts;
    tick(30);
    chk(frame_active == 1, "R7", "frame held during stall", int'(frame_active), 1);
    chk(total_starts == f0, "R7", "starts during stall", total_starts - f0, 0);
    tx_rdy = 1'b1;
    wait_empty();
    chk(xfer_done == 1, "R7", "done after stall", int'(xfer_done), 1);

    // R8: no frame opens without a ready FIFO
    setup(2, 0, 1, 0, 0);
    f0 = frame_falls;
    tick(20);
    chk(frame_active == 0, "R8", "frame opened without FIFO", int'(frame_active), 0);
    push_frames(1, 2, 0, 0, "R8");
    tx_rdy = 1'b1;
    wait_empty();

    // R1: disable clears the count, so re-enable streams
    mon_ignore = 1'b1;
    tx_rdy = 1'b0;
    ctl_en = 1'b0;
    tick(3);
    ctl_en = 1'b1;
    tick(2);
    mon_ignore = 1'b0;
    s0 = total_starts; f0 = frame_falls;
    tx_rdy = 1'b1;
    tick(60);
    chk(frame_active == 1 && xfer_done == 0, "R1", "stream after disable clears count",
        int'({frame_active, xfer_done}), 2);
    chk(total_starts - s0 >= 8, "R1", "bytes after re-enable", total_starts - s0, 8);
    chk(frame_falls == f0, "R1", "frame ends after re-enable", frame_falls - f0, 0);
    mon_ignore = 1'b1;
    ctl_en = 1'b0;
    tick(3);

    finish_run();
  end

endmodule